// File: doc/BRIEF.md
# Memory-Mapped Iterative Integer Divider

This block is a 32-bit integer divider that sits on a register bus where every access finishes in one cycle. Software writes a dividend and a divisor. Each operand has two addresses: one marks the operation as signed and the other as unsigned. Each operand write starts a new division from the operand values as they stand after that write. The datapath works only on magnitudes and settles four quotient bits per clock, so both results are complete eight clock edges after the last operand write. The sign of the results is corrected on the read path, using the alias that was written last.

Two status flags describe the divider state. The ready flag shows that the results are complete. The dirty flag shows that an operation has been started since the quotient was last read. The quotient and remainder registers can also be written directly, which lets an interrupt handler put back a saved divider state. The handler reads the operands, then the remainder, then the quotient. To restore, it writes the operands through the unsigned addresses, then the remainder, then the quotient.

Top module: `mmio_divider`

## Requirements
- R1: After reset, the status register reads 0x1 (ready, not dirty), and the dividend, divisor, quotient and remainder registers all read 0.
- R2: The status register holds ready at bit 0 and dirty at bit 1; all its other bits read 0. Writes to the status register and to the spare word 7 change no register. Word 7 reads 0.
- R3: A write to any operand word (0, 1, 2, 3) clears ready and sets dirty. Ready then reads 0 after each of the next 7 rising edges and reads 1 after the 8th.
- R4: An operation started by an unsigned operand write (word 0 or 1) with a nonzero divisor gives quotient = floor(dividend/divisor) and remainder = dividend mod divisor, both taken as unsigned 32-bit values.
- R5: An operation started by a signed operand write (word 2 or 3) treats both operands as two's complement. The quotient is truncated toward zero and the remainder takes the sign of the dividend. The most-negative dividend divided by -1 returns 0x80000000. Signed or unsigned is set by the alias of the most recent operand write. Words 0 and 2 both read back the raw dividend; words 1 and 3 both read back the raw divisor.
- R6: With a zero divisor, the quotient reads 0xFFFFFFFF and the remainder reads the dividend, in both modes. Ready is still set after 8 edges.
- R7: A read of the quotient (word 4) clears dirty. Reads of the remainder or the status leave dirty unchanged.
- R8: A write to the quotient (word 4) or the remainder (word 5) stores the written value and stops any operation in flight. Ready reads 1 from the next cycle and dirty keeps its value. The other result register then holds its value. In unsigned mode, the written value reads back unchanged.
- R9: An operand write during an operation restarts it from the current operand values. The 8-edge latency counts from the newest write, including a write that falls on the edge where the earlier operation would have finished.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word index: 0 unsigned dividend, 1 unsigned divisor, 2 signed dividend, 3 signed divisor, 4 quotient, 5 remainder, 6 status, 7 spare |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; its only effect is the side effect on dirty at the rising edge |
| bus_rdata | output | 32 | Combinational read data for the word selected by bus_addr |

## Verification
An operand write and the completion of an earlier operation can fall on the same clock edge. The bench provokes this by writing a new divisor exactly eight edges after the first operation started. It then judges the result by checking that ready stays low through the next seven edges and that the quotient and remainder belong to the new divisor. A direct result write can also land on the same edge as a pending iteration. That case is judged by checking that ready rises at once and that the other result register stays frozen over the following cycles.

// File: rtl/divider_pkg.sv
package divider_pkg;

    // word index of each register on the bus
    typedef enum logic [2:0] {
        IDX_U_NUM = 3'd0,
        IDX_U_DEN = 3'd1,
        IDX_S_NUM = 3'd2,
        IDX_S_DEN = 3'd3,
        IDX_QUOT  = 3'd4,
        IDX_REMD  = 3'd5,
        IDX_STAT  = 3'd6,
        IDX_SPARE = 3'd7
    } reg_idx_e;

    localparam int STAT_READY_BIT = 0;
    localparam int STAT_DIRTY_BIT = 1;

    // what a bus access to a given word touches
    typedef struct packed {
        logic operand;  // dividend or divisor word
        logic numer;    // dividend rather than divisor
        logic sgn;      // signed alias
        logic quot;     // quotient word
        logic remd;     // remainder word
    } access_t;

    function automatic access_t classify(input logic [2:0] idx);
        access_t a;
        a.operand = (idx[2] == 1'b0);
        a.numer   = (idx[0] == 1'b0);
        a.sgn     = idx[1];
        a.quot    = (idx == IDX_QUOT);
        a.remd    = (idx == IDX_REMD);
        return a;
    endfunction

endpackage

// File: rtl/div_negate.sv
module div_negate #(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    input  logic         neg_i,
    output logic [W-1:0] val_o
);
    assign val_o = neg_i ? (-val_i) : val_i;
endmodule

// File: rtl/div_core.sv
module div_core #(
    parameter int DATA_W    = 32,
    parameter int STEP_BITS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] num_mag,
    input  logic [DATA_W-1:0] den_mag,
    input  logic              ld_q,
    input  logic              ld_r,
    input  logic [DATA_W-1:0] ld_val,
    output logic [DATA_W-1:0] q_raw,
    output logic [DATA_W-1:0] r_raw,
    output logic              busy
);
    localparam int STEPS = DATA_W / STEP_BITS;
    localparam int CW    = $clog2(STEPS + 1);

    logic [DATA_W-1:0] q_r, r_r, d_r;
    logic [CW-1:0]     cnt;

    // chain of restoring shift-subtract stages, STEP_BITS per clock
    logic [DATA_W-1:0] qc [STEP_BITS+1];
    logic [DATA_W-1:0] rc [STEP_BITS+1];

    assign qc[0] = q_r;
    assign rc[0] = r_r;

    for (genvar g = 0; g < STEP_BITS; g++) begin : g_step
        logic [DATA_W:0]   trial;
        logic              ge;
        logic [DATA_W-1:0] sub;
        assign trial     = {rc[g], qc[g][DATA_W-1]};
        assign ge        = (trial >= {1'b0, d_r});
        assign sub       = trial[DATA_W-1:0] - d_r;
        assign rc[g+1]   = ge ? sub : trial[DATA_W-1:0];
        assign qc[g+1]   = {qc[g][DATA_W-2:0], ge};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
            r_r <= '0;
            d_r <= '0;
            cnt <= '0;
        end else if (start) begin
            q_r <= num_mag;
            r_r <= '0;
            d_r <= den_mag;
            cnt <= CW'(STEPS);
        end else if (ld_q || ld_r) begin
            cnt <= '0;
            if (ld_q) q_r <= ld_val;
            if (ld_r) r_r <= ld_val;
        end else if (cnt != '0) begin
            q_r <= qc[STEP_BITS];
            r_r <= rc[STEP_BITS];
            cnt <= cnt - CW'(1);
        end
    end

    assign q_raw = q_r;
    assign r_raw = r_r;
    assign busy  = (cnt != '0);

    logic finishing;
    assign finishing = (cnt == CW'(1)) && !start && !ld_q && !ld_r;

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(STEPS));

    assert_finish_idle_R3: assert property (@(posedge clk) disable iff (rst)
        finishing |=> !busy);

    assert_zero_div_R6: assert property (@(posedge clk) disable iff (rst)
        (finishing && d_r == '0) |=> (q_r == '1));

    assert_rem_below_den_R4: assert property (@(posedge clk) disable iff (rst)
        (finishing && d_r != '0) |=> (r_r < d_r));

    assert_load_halts_R8: assert property (@(posedge clk) disable iff (rst)
        (ld_q && !ld_r && !start) |=> $stable(r_r));

endmodule

// File: rtl/mmio_divider.sv
module mmio_divider
    import divider_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int STEP_BITS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int MSB   = DATA_W - 1;
    localparam int N_NEG = 4;

    access_t  acc;
    reg_idx_e sel;
    assign acc = classify(bus_addr);
    assign sel = reg_idx_e'(bus_addr);

    logic op_wr, q_wr, r_wr, q_rd;
    assign op_wr = bus_wr && acc.operand;
    assign q_wr  = bus_wr && acc.quot;
    assign r_wr  = bus_wr && acc.remd;
    assign q_rd  = bus_rd && acc.quot;

    logic [DATA_W-1:0] num_r, den_r;
    logic              sgn_r, qneg_r, rneg_r, dirty_r;
    logic [DATA_W-1:0] nxt_num, nxt_den;

    assign nxt_num = (op_wr &&  acc.numer) ? bus_wdata : num_r;
    assign nxt_den = (op_wr && !acc.numer) ? bus_wdata : den_r;

    logic [DATA_W-1:0] q_raw, r_raw;
    logic              busy;

    // sign units: 0 dividend magnitude, 1 divisor magnitude,
    // 2 quotient read correction, 3 remainder read correction
    logic [DATA_W-1:0] nf_in  [N_NEG];
    logic [DATA_W-1:0] nf_out [N_NEG];
    logic              nf_neg [N_NEG];

    assign nf_in[0]  = nxt_num;
    assign nf_neg[0] = acc.sgn && nxt_num[MSB];
    assign nf_in[1]  = nxt_den;
    assign nf_neg[1] = acc.sgn && nxt_den[MSB];
    assign nf_in[2]  = q_raw;
    assign nf_neg[2] = sgn_r && qneg_r;
    assign nf_in[3]  = r_raw;
    assign nf_neg[3] = sgn_r && rneg_r;

    for (genvar u = 0; u < N_NEG; u++) begin : g_neg
        div_negate #(.W(DATA_W)) u_neg (
            .val_i (nf_in[u]),
            .neg_i (nf_neg[u]),
            .val_o (nf_out[u])
        );
    end

    div_core #(.DATA_W(DATA_W), .STEP_BITS(STEP_BITS)) u_core (
        .clk     (clk),
        .rst     (rst),
        .start   (op_wr),
        .num_mag (nf_out[0]),
        .den_mag (nf_out[1]),
        .ld_q    (q_wr),
        .ld_r    (r_wr),
        .ld_val  (bus_wdata),
        .q_raw   (q_raw),
        .r_raw   (r_raw),
        .busy    (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            num_r  <= '0;
            den_r  <= '0;
            sgn_r  <= 1'b0;
            qneg_r <= 1'b0;
            rneg_r <= 1'b0;
        end else if (op_wr) begin
            num_r  <= nxt_num;
            den_r  <= nxt_den;
            sgn_r  <= acc.sgn;
            qneg_r <= (nxt_num[MSB] ^ nxt_den[MSB]) && (nxt_den != '0);
            rneg_r <= nxt_num[MSB];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        dirty_r <= 1'b0;
        else if (op_wr) dirty_r <= 1'b1;
        else if (q_rd)  dirty_r <= 1'b0;
    end

    logic [DATA_W-1:0] stat_word;
    always_comb begin
        stat_word = '0;
        stat_word[STAT_READY_BIT] = !busy;
        stat_word[STAT_DIRTY_BIT] = dirty_r;
    end

    always_comb begin
        case (sel)
            IDX_U_NUM, IDX_S_NUM: bus_rdata = num_r;
            IDX_U_DEN, IDX_S_DEN: bus_rdata = den_r;
            IDX_QUOT:             bus_rdata = nf_out[2];
            IDX_REMD:             bus_rdata = nf_out[3];
            IDX_STAT:             bus_rdata = stat_word;
            default:              bus_rdata = '0;
        endcase
    end

    assert_operand_starts_R3: assert property (@(posedge clk) disable iff (rst)
        op_wr |=> (busy && dirty_r));

    assert_result_write_R8: assert property (@(posedge clk) disable iff (rst)
        ((q_wr || r_wr) && !bus_rd) |=> (!busy && dirty_r == $past(dirty_r)));

    assert_quot_read_clean_R7: assert property (@(posedge clk) disable iff (rst)
        q_rd |=> !dirty_r);

    assert_stat_write_inert_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == IDX_STAT) |=> ($stable(num_r) && $stable(den_r) && $stable(dirty_r)));

endmodule

// File: tb/mmio_divider_test.sv
module mmio_divider_test;
    import divider_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmio_divider uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        bus_addr  = idx;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] d);
        bus_addr = idx;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic expect_div(input logic [31:0] a, b, input logic sgn,
                              output logic [31:0] q, r);
        logic [31:0] am, bm, qm, rm;
        if (b == 0) begin
            q = 32'hFFFF_FFFF;
            r = a;
        end else if (!sgn) begin
            q = a / b;
            r = a % b;
        end else begin
            am = a[31] ? -a : a;
            bm = b[31] ? -b : b;
            qm = am / bm;
            rm = am % bm;
            q  = (a[31] ^ b[31]) ? -qm : qm;
            r  = a[31] ? -rm : rm;
        end
    endtask

    task automatic run_op(input logic [31:0] a, b, input logic sa, sb, input string tag);
        logic [31:0] eq, er, got;
        expect_div(a, b, sb, eq, er);
        wr(sa ? IDX_S_NUM : IDX_U_NUM, a);
        wr(sb ? IDX_S_DEN : IDX_U_DEN, b);
        idle(7);
        rd(IDX_STAT, got); check("R3 not ready after 7 edges", got, 32'h2);
        rd(IDX_STAT, got); check("R3 ready after 8th edge", got, 32'h3);
        rd(IDX_REMD, got); check({tag, " remainder"}, got, er);
        rd(IDX_STAT, got); check("R7 dirty kept after remainder read", got, 32'h3);
        rd(IDX_QUOT, got); check({tag, " quotient"}, got, eq);
        rd(IDX_STAT, got); check("R7 dirty cleared by quotient read", got, 32'h1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] got, p, eq, er;
        logic [31:0] ua [8];
        logic [31:0] ub [6];
        logic [31:0] sa [8];
        logic [31:0] sb [6];
        ua = '{32'd0, 32'd1, 32'd7, 32'd100, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1234_5678, 32'd999999};
        ub = '{32'd1, 32'd3, 32'd7, 32'd0, 32'hFFFF_FFFF, 32'h0001_0000};
        sa = '{-32'sd7, 32'sd7, -32'sd1, 32'sd0, 32'h8000_0000, 32'h7FFF_FFFF, 32'sd13, -32'sd100};
        sb = '{32'sd3, -32'sd3, 32'sd1, -32'sd1, 32'sd0, 32'h8000_0000};

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(IDX_STAT, got);  check("R1 status after reset", got, 32'h1);
        rd(IDX_U_NUM, got); check("R1 dividend after reset", got, 0);
        rd(IDX_U_DEN, got); check("R1 divisor after reset", got, 0);
        rd(IDX_REMD, got);  check("R1 remainder after reset", got, 0);
        rd(IDX_QUOT, got);  check("R1 quotient after reset", got, 0);

        // R4 / R6 unsigned sweep
        foreach (ua[i]) foreach (ub[j])
            run_op(ua[i], ub[j], 1'b0, 1'b0, (ub[j] == 0) ? "R6 unsigned" : "R4");

        // R5 / R6 signed sweep
        foreach (sa[i]) foreach (sb[j])
            run_op(sa[i], sb[j], 1'b1, 1'b1, (sb[j] == 0) ? "R6 signed" : "R5");

        // R5 mode follows the last alias written
        run_op(-32'sd20, 32'sd3, 1'b1, 1'b0, "R5 signed then unsigned alias");
        run_op(-32'sd20, 32'sd3, 1'b0, 1'b1, "R5 unsigned then signed alias");

        // R5 raw operand readback through both aliases
        rd(IDX_U_NUM, got); check("R5 dividend via unsigned word", got, -32'sd20);
        rd(IDX_S_NUM, got); check("R5 dividend via signed word", got, -32'sd20);
        rd(IDX_U_DEN, got); check("R5 divisor via unsigned word", got, 32'sd3);
        rd(IDX_S_DEN, got); check("R5 divisor via signed word", got, 32'sd3);

        // R2 status format and inert writes
        wr(IDX_STAT, 32'hFFFF_FFFF);
        rd(IDX_STAT, got);  check("R2 status write ignored", got, 32'h1);
        wr(IDX_SPARE, 32'h5555_5555);
        rd(IDX_SPARE, got); check("R2 spare word reads zero", got, 0);
        rd(IDX_U_NUM, got); check("R2 dividend unchanged", got, -32'sd20);
        rd(IDX_U_DEN, got); check("R2 divisor unchanged", got, 32'sd3);
        rd(IDX_STAT, got);  check("R2 status unchanged", got, 32'h1);

        // R8 direct result write halts the operation
        wr(IDX_U_NUM, 32'd1000);
        wr(IDX_U_DEN, 32'd7);
        idle(2);
        wr(IDX_QUOT, 32'hDEAD_BEEF);
        rd(IDX_STAT, got);  check("R8 ready at once, dirty kept", got, 32'h3);
        rd(IDX_REMD, p);
        idle(3);
        rd(IDX_REMD, got);  check("R8 remainder frozen", got, p);
        rd(IDX_STAT, got);  check("R8 still ready", got, 32'h3);
        rd(IDX_QUOT, got);  check("R8 quotient stored value", got, 32'hDEAD_BEEF);
        rd(IDX_STAT, got);  check("R8 quotient read clears dirty", got, 32'h1);
        wr(IDX_REMD, 32'h0000_1234);
        rd(IDX_STAT, got);  check("R8 dirty stays clear", got, 32'h1);
        rd(IDX_REMD, got);  check("R8 remainder stored value", got, 32'h0000_1234);

        // R9 restart on the edge the first operation would finish
        wr(IDX_U_NUM, 32'd100);
        wr(IDX_U_DEN, 32'd3);
        idle(7);
        wr(IDX_U_DEN, 32'd9);
        rd(IDX_STAT, got);  check("R9 restart clears ready", got, 32'h2);
        idle(6);
        rd(IDX_STAT, got);  check("R9 not ready 7 edges after restart", got, 32'h2);
        rd(IDX_STAT, got);  check("R9 ready 8 edges after restart", got, 32'h3);
        rd(IDX_REMD, got);  check("R9 remainder of new divisor", got, 32'd1);
        rd(IDX_QUOT, got);  check("R9 quotient of new divisor", got, 32'd11);

        // R9 mid-flight restart with a change of mode
        wr(IDX_S_NUM, -32'sd20);
        wr(IDX_S_DEN, 32'sd3);
        idle(3);
        wr(IDX_U_DEN, 32'd3);
        idle(8);
        expect_div(-32'sd20, 32'd3, 1'b0, eq, er);
        rd(IDX_STAT, got);  check("R9 ready after mid-flight restart", got, 32'h3);
        rd(IDX_REMD, got);  check("R9 unsigned remainder after restart", got, er);
        rd(IDX_QUOT, got);  check("R9 unsigned quotient after restart", got, eq);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule